// File: doc/BRIEF.md
# Complementary PWM Dead-Time Inserter

This block takes one reference PWM waveform and drives two complementary outputs from it: a main output that follows the reference and a complementary output that follows its inverse. After every reference edge it holds both outputs inactive for a programmable gap, so the two switches of a half bridge are never on at the same time. The gap is counted in pulses of a dead-time clock enable (`tick_i`). It is not counted in system clocks.

Each gap length comes from an 8-bit code. The code is decoded piecewise into four ranges, and each range has its own tick multiplier. The gap after a rising reference edge uses the rising code. The gap after a falling reference edge uses either the rising code or a separate falling code, depending on an asymmetric-mode bit.

A small write-only register port loads the codes and the mode bits. A lock-level input blocks all writes while it is non-zero. When the preload bit is set, new codes wait in shadow registers and only move to the active set on an update-event pulse.

Top module: `dt_inserter`

## Requirements
- R1: `main_o` and `comp_o` are never both 1.
- R2: A code c decodes to a tick count D:
  - c[7]=0 gives D = c.
  - c[7:5]=10x gives D = (64 + c[5:0]) * 2.
  - c[7:5]=110 gives D = (32 + c[4:0]) * 8.
  - c[7:5]=111 gives D = (32 + c[4:0]) * 16.
- R3: When the clock edge samples `ref_i` rising, `comp_o` goes 0 after that edge. With `tick_i` held at 1 and D > 0, `main_o` goes 1 after the D-th following edge. Outputs are registered.
- R4: A falling reference edge is handled the same way with the two outputs swapped. It uses the falling code when the asymmetric bit is 1 and the rising code when that bit is 0.
- R5: If `ref_i` changes again before the count ends, both outputs stay 0 and the count restarts from the new edge's delay. A pulse shorter than the delay never reaches `main_o`.
- R6: A delay of 0 makes the outputs switch after the same clock edge that samples the reference change.
- R7: Register map and reset values:
  - A write with `wr_sel_i`=0 loads the rising code from `wr_data_i[7:0]`.
  - A write with `wr_sel_i`=1 loads the falling code from bits 7:0, the asymmetric bit from bit 16 and the preload bit from bit 17.
  - All of these fields reset to 0.
- R8: A write while `lock_i` is non-zero (level 1, 2 or 3) changes nothing.
- R9: Preload behaviour:
  - While the stored preload bit is 1, written codes go only to the shadow registers.
  - An `update_i` pulse copies the shadow codes to the active set.
  - While the preload bit is 0, written codes become active at once.
  - The asymmetric and preload bits always take effect at once.
- R10: After reset, `main_o`=0 and `comp_o`=1.
- R11: The dead-time count advances only on clock edges where `tick_i` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Dead-time clock enable |
| ref_i | input | 1 | Reference PWM input |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | 0: rising-code word, 1: falling/control word |
| wr_data_i | input | 32 | Write data |
| lock_i | input | 2 | Lock level; non-zero blocks writes |
| update_i | input | 1 | Update event; copies shadow codes to the active set |
| main_o | output | 1 | Main output |
| comp_o | output | 1 | Complementary output |

## Verification
The output that goes inactive is due one clock edge after the edge that samples the reference change. The output that goes active is due after D further edges on which `tick_i` is high, or on that same first edge when D is 0. A register write is seen by the next reference edge after the clock edge that takes it. The bench drives all inputs on falling clock edges and steps a behavioural model on each rising edge. It compares both outputs at the following falling edge, so every expected transition is sampled one full edge after it is due. Directed delay checks count falling edges from the reference change until the output rises, then subtract the one edge of registering.

// File: rtl/dt_pkg.sv
package dt_pkg;
  localparam int CODE_W   = 8;
  localparam int TICK_W   = 10;  // max decode (32+31)*16 = 1008
  localparam int WORD_W   = 32;
  localparam int ASYM_BIT = 16;
  localparam int PRE_BIT  = 17;

  typedef logic [CODE_W-1:0] code_t;
  typedef logic [TICK_W-1:0] ticks_t;

  typedef struct packed {
    code_t rise;
    code_t fall;
    logic  asym;
  } dt_cfg_t;
endpackage

// File: rtl/dt_code_decode.sv
module dt_code_decode
  import dt_pkg::*;
(
  input  code_t  code_i,
  output ticks_t ticks_o
);
  always_comb begin
    casez (code_i[7:5])
      3'b0??:  ticks_o = TICK_W'(code_i);
      3'b10?:  ticks_o = TICK_W'({1'b1, code_i[5:0]}) << 1;
      3'b110:  ticks_o = TICK_W'({1'b1, code_i[4:0]}) << 3;
      default: ticks_o = TICK_W'({1'b1, code_i[4:0]}) << 4;
    endcase
  end

  // only the all-zero code may yield a zero delay
  always_comb begin
    if (!$isunknown(code_i))
      assert_zero_only_from_zero_R2: assert (code_i == '0 || ticks_o != '0);
  end
endmodule

// File: rtl/dt_cfg_regs.sv
module dt_cfg_regs
  import dt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              wr_sel_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic [1:0]        lock_i,
  input  logic              update_i,
  output dt_cfg_t           cfg_o
);
  code_t sh_rise_q, sh_fall_q, act_rise_q, act_fall_q;
  logic  asym_q, pre_q;
  logic  wr_ok;

  logic unused_bits;
  assign unused_bits = ^{wr_data_i[WORD_W-1:PRE_BIT+1], wr_data_i[ASYM_BIT-1:CODE_W]};

  assign wr_ok = wr_en_i && (lock_i == 2'd0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_rise_q  <= '0;
      sh_fall_q  <= '0;
      act_rise_q <= '0;
      act_fall_q <= '0;
      asym_q     <= 1'b0;
      pre_q      <= 1'b0;
    end else begin
      if (update_i) begin
        act_rise_q <= sh_rise_q;
        act_fall_q <= sh_fall_q;
      end
      if (wr_ok && !wr_sel_i) begin
        sh_rise_q <= wr_data_i[CODE_W-1:0];
        if (!pre_q) act_rise_q <= wr_data_i[CODE_W-1:0];
      end
      if (wr_ok && wr_sel_i) begin
        sh_fall_q <= wr_data_i[CODE_W-1:0];
        if (!pre_q) act_fall_q <= wr_data_i[CODE_W-1:0];
        asym_q <= wr_data_i[ASYM_BIT];
        pre_q  <= wr_data_i[PRE_BIT];
      end
    end
  end

  assign cfg_o = '{rise: act_rise_q, fall: act_fall_q, asym: asym_q};

  assert_lock_blocks_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && lock_i != 2'd0) |=>
      ($stable(sh_rise_q) && $stable(sh_fall_q) && $stable(asym_q) && $stable(pre_q)));

  assert_preload_holds_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pre_q && !update_i) |=> ($stable(act_rise_q) && $stable(act_fall_q)));
endmodule

// File: rtl/dt_edge_gen.sv
module dt_edge_gen
  import dt_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    tick_i,
  input  logic    ref_i,
  input  dt_cfg_t cfg_i,
  output logic    main_o,
  output logic    comp_o
);
  localparam int NUM_EDGE = 2;  // 0: rising, 1: falling

  code_t  codes [NUM_EDGE];
  ticks_t dly   [NUM_EDGE];
  ticks_t dly_sel;

  assign codes[0] = cfg_i.rise;
  assign codes[1] = cfg_i.fall;

  for (genvar g = 0; g < NUM_EDGE; g++) begin : g_dec
    dt_code_decode u_dec (
      .code_i  (codes[g]),
      .ticks_o (dly[g])
    );
  end

  assign dly_sel = (ref_i || !cfg_i.asym) ? dly[0] : dly[1];

  logic   ref_q, main_q, comp_q, busy_q;
  ticks_t cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_q  <= 1'b0;
      main_q <= 1'b0;
      comp_q <= 1'b1;
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (ref_i != ref_q) begin
      ref_q <= ref_i;
      if (dly_sel == '0) begin
        main_q <= ref_i;
        comp_q <= ~ref_i;
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        main_q <= 1'b0;
        comp_q <= 1'b0;
        busy_q <= 1'b1;
        cnt_q  <= dly_sel;
      end
    end else if (busy_q && tick_i) begin
      if (cnt_q == TICK_W'(1)) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
        main_q <= ref_q;
        comp_q <= ~ref_q;
      end else begin
        cnt_q <= cnt_q - TICK_W'(1);
      end
    end
  end

  assign main_o = main_q;
  assign comp_o = comp_q;

  assert_no_overlap_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(main_o && comp_o));

  assert_comp_drops_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_i && !$past(ref_i)) |=> !comp_o);

  assert_main_after_high_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(main_o) |-> $past(ref_i));

  assert_pending_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (!main_o && !comp_o && cnt_q != '0));

  assert_tick_gates_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !tick_i && ref_i == ref_q) |=> $stable(cnt_q));
endmodule

// File: rtl/dt_inserter.sv
module dt_inserter
  import dt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              ref_i,
  input  logic              wr_en_i,
  input  logic              wr_sel_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic [1:0]        lock_i,
  input  logic              update_i,
  output logic              main_o,
  output logic              comp_o
);
  dt_cfg_t cfg;

  dt_cfg_regs u_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_sel_i  (wr_sel_i),
    .wr_data_i (wr_data_i),
    .lock_i    (lock_i),
    .update_i  (update_i),
    .cfg_o     (cfg)
  );

  dt_edge_gen u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .ref_i  (ref_i),
    .cfg_i  (cfg),
    .main_o (main_o),
    .comp_o (comp_o)
  );
endmodule

// File: tb/dt_inserter_tb.sv
module dt_inserter_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b1;
  logic        ref_s = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_sel = 1'b0;
  logic [31:0] wr_data = '0;
  logic [1:0]  lock = 2'd0;
  logic        upd = 1'b0;
  logic        main_s, comp_s;

  int    errors = 0;
  int    checks = 0;
  int    tick_mode = 0;
  bit    done = 1'b0;
  string cur_req = "R3";

  always #2 clk = ~clk;

  dt_inserter u_dut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .tick_i    (tick),
    .ref_i     (ref_s),
    .wr_en_i   (wr_en),
    .wr_sel_i  (wr_sel),
    .wr_data_i (wr_data),
    .lock_i    (lock),
    .update_i  (upd),
    .main_o    (main_s),
    .comp_o    (comp_s)
  );

  // decode rule from R2
  function automatic int dec(input logic [7:0] c);
    if (!c[7])          return int'(c);
    else if (!c[6])     return (64 + int'(c[5:0])) * 2;
    else if (!c[5])     return (32 + int'(c[4:0])) * 8;
    else                return (32 + int'(c[4:0])) * 16;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // behavioural reference model
  logic [7:0] m_rs, m_fs, m_ra, m_fa;
  logic       m_asym, m_pre, m_ref, m_main, m_comp;
  int         m_left, m_d;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_rs = 0; m_fs = 0; m_ra = 0; m_fa = 0; m_asym = 0; m_pre = 0;
      m_ref = 0; m_main = 0; m_comp = 1; m_left = 0;
    end else begin
      if (ref_s != m_ref) begin
        m_d = ref_s ? dec(m_ra) : (m_asym ? dec(m_fa) : dec(m_ra));
        m_ref = ref_s;
        if (m_d == 0) begin m_main = ref_s; m_comp = !ref_s; m_left = 0; end
        else begin m_main = 0; m_comp = 0; m_left = m_d; end
      end else if (m_left > 0 && tick) begin
        m_left--;
        if (m_left == 0) begin m_main = m_ref; m_comp = !m_ref; end
      end
      if (upd) begin m_ra = m_rs; m_fa = m_fs; end
      if (wr_en && lock == 0) begin
        if (!wr_sel) begin
          m_rs = wr_data[7:0];
          if (!m_pre) m_ra = wr_data[7:0];
        end else begin
          m_fs = wr_data[7:0];
          if (!m_pre) m_fa = wr_data[7:0];
          m_asym = wr_data[16];
          m_pre  = wr_data[17];
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      check(main_s == m_main && comp_s == m_comp, cur_req,
            {main_s, comp_s}, {m_main, m_comp});
      check(!(main_s && comp_s), "R1", {main_s, comp_s}, 0);
    end
    tick <= (tick_mode == 0) ? 1'b1 : ~tick;
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic sel, input logic [31:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  // drive ref high from a settled low state, count edges to main rising
  task automatic meas_rise(input int exp, input string req);
    int n = 0;
    ref_s = 1'b1;
    do begin @(negedge clk); n++; end while (!main_s && n < 1100);
    check(n - 1 == exp, req, n - 1, exp);
  endtask

  task automatic meas_fall(input int exp, input string req);
    int n = 0;
    ref_s = 1'b0;
    do begin @(negedge clk); n++; end while (!comp_s && n < 1100);
    check(n - 1 == exp, req, n - 1, exp);
  endtask

  task automatic settle_low();
    int n = 0;
    ref_s = 1'b0;
    do begin @(negedge clk); n++; end while (!comp_s && n < 1100);
    step(2);
  endtask

  initial begin
    logic [7:0] codes [8] = '{8'h05, 8'h7F, 8'h80, 8'hA3, 8'hC0, 8'hDF, 8'hE1, 8'hFF};
    step(3);
    rst_n = 1'b1;
    @(negedge clk);
    cur_req = "R10";
    check(main_s == 1'b0 && comp_s == 1'b1, "R10", {main_s, comp_s}, 1);

    // R7 reset code is zero: immediate switch
    cur_req = "R7";
    meas_rise(0, "R7");
    settle_low();

    // R2 decode ranges
    cur_req = "R2";
    foreach (codes[i]) begin
      wr(1'b0, {24'd0, codes[i]});
      step(1);
      meas_rise(dec(codes[i]), "R2");
      settle_low();
    end

    // R6 zero delay both directions
    cur_req = "R6";
    wr(1'b0, 32'd0);
    meas_rise(0, "R6");
    meas_fall(0, "R6");
    step(2);

    // R4 asymmetric falling delay
    cur_req = "R4";
    wr(1'b0, 32'd3);
    wr(1'b1, (32'd1 << 16) | 32'h10);
    meas_rise(3, "R4");
    step(2);
    meas_fall(16, "R4");
    step(2);
    wr(1'b1, 32'h10);
    meas_rise(3, "R4");
    step(2);
    meas_fall(3, "R4");
    step(2);

    // R5 short pulse absorbed
    cur_req = "R5";
    wr(1'b0, 32'd10);
    ref_s = 1'b1;
    step(4);
    ref_s = 1'b0;
    begin
      bit seen = 1'b0;
      for (int i = 0; i < 30; i++) begin
        @(negedge clk);
        if (main_s) seen = 1'b1;
      end
      check(!seen, "R5", seen, 0);
    end
    check(comp_s == 1'b1, "R5", comp_s, 1);

    // R8 lock blocks writes
    cur_req = "R8";
    wr(1'b0, 32'd6);
    lock = 2'd1;
    wr(1'b0, 32'h20);
    lock = 2'd3;
    wr(1'b1, (32'd1 << 17) | (32'd1 << 16) | 32'h40);
    lock = 2'd0;
    step(1);
    meas_rise(6, "R8");
    step(2);
    meas_fall(6, "R8");
    step(2);

    // R9 preload
    cur_req = "R9";
    wr(1'b1, 32'd1 << 17);
    wr(1'b0, 32'd9);
    step(1);
    meas_rise(6, "R9");
    settle_low();
    upd = 1'b1; @(negedge clk); upd = 1'b0;
    meas_rise(9, "R9");
    settle_low();
    wr(1'b1, 32'd0);
    wr(1'b0, 32'd2);
    step(1);
    meas_rise(2, "R9");
    settle_low();

    // R11 tick gating against the model
    cur_req = "R11";
    wr(1'b0, 32'd4);
    tick_mode = 1;
    for (int k = 0; k < 6; k++) begin
      ref_s = ~ref_s;
      step(5 + 4 * k);
    end
    tick_mode = 0;
    settle_low();

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule